// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is the serial front end of a sensor. An SPI master reaches a small map of 16-bit registers through it. The map is byte addressed: each register spans two byte addresses. Every transaction is one 16-bit frame, and frames are full duplex. Each command frame carries three fields:

- a write flag,
- a 7-bit byte address,
- an 8-bit payload, which is the data for a write and is ignored for a read.

A read is answered one frame later. While the master sends its next command, the slave shifts out the word that the earlier command asked for. A write stores exactly one byte. Software therefore fills a 16-bit register in two frames, low byte first and then high byte.

All three SPI inputs are brought into the system clock domain through multi-stage synchronisers. Framing, decoding and register access then run on the system clock. The register bank inside the block has three kinds of location:

- a window of writable word registers built from two byte-lane memories,
- one read-only identification word,
- everything else, which is reserved and reads as zero.

The master-in/slave-out data line comes out as a data bit plus an output enable, so the pad ring can build the three-state driver.

Top module: `spi_regport`

## Requirements
- R1: The interface uses SPI mode 3. SCLK idles high, and the slave samples MOSI on SCLK rising edges. Frames are 16 bits, most significant bit first. On MISO, bit k of the response is valid for the master's k-th rising edge.
- R2: In a command word, bit 15 is the write flag (1 = write, 0 = read). Bits 14:8 hold the byte address, and bits 7:0 hold the write data, which is ignored for a read. Each complete frame causes at most one register access.
- R3: The 16-bit word requested by a read frame is shifted out on MISO during the next complete frame, while that frame's command is being received.
- R4: If the previous complete frame was a write, MISO carries all zeros during the current frame.
- R5: spi_miso_oe is low whenever chip select is high, and high while a frame is in progress.
- R6: A write to an even byte address changes only bits 7:0 of that register. A write to the odd address changes only bits 15:8.
- R7: A read at either byte address of a register returns the full 16-bit word.
- R8: The identification register at byte addresses 0x72/0x73 reads as 0x407B. Writes to it have no effect.
- R9: Byte addresses outside the writable window and the identification register read as 0x0000. Writes to them have no effect.
- R10: A frame whose chip select rises before 16 bits have been clocked is dropped. It performs no access, and the pending response is sent again in the next complete frame.
- R11: SCLK edges after the 16th within one chip-select window are ignored.
- R12: After reset, the output enable is low and the first frame returns 0x0000 on MISO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master, idles high |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Command bits from the master |
| spi_miso | output | 1 | Response bit to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |

## Verification
The embedded properties rely on three assumptions about the inputs:

- SCLK runs several times slower than the system clock, so that every SCLK level spans a few system cycles after synchronisation.
- Chip select falls and rises only while SCLK is high.
- Consecutive frames are separated by enough system cycles for a read response to be latched before the next frame starts.

The stimulus holds each SCLK half period for eight system clocks. It leaves several system cycles on both sides of each chip-select change, and it changes every input on the falling system-clock edge. Register locations are read back only after both of their bytes have been written.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int CMD_ADDR_W = 7;
  localparam int CMD_DATA_W = 8;
  localparam int FRAME_W    = 1 + CMD_ADDR_W + CMD_DATA_W;

  typedef struct packed {
    logic                  wr;
    logic [CMD_ADDR_W-1:0] addr;
    logic [CMD_DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic cs_start,
  output logic cs_active,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_pipe, csn_pipe, mosi_pipe;
  logic sclk_d, csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_pipe <= '1;
      csn_pipe  <= '1;
      mosi_pipe <= '0;
      sclk_d    <= 1'b1;
      csn_d     <= 1'b1;
    end else begin
      sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_i};
      csn_pipe  <= {csn_pipe[STAGES-2:0], csn_i};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_i};
      sclk_d    <= sclk_pipe[STAGES-1];
      csn_d     <= csn_pipe[STAGES-1];
    end
  end

  assign sclk_rise = sclk_pipe[STAGES-1] & ~sclk_d;
  assign cs_start  = ~csn_pipe[STAGES-1] & csn_d;
  assign cs_active = ~csn_pipe[STAGES-1];
  assign mosi_s    = mosi_pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_regport_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_rise,
  input  logic                  cs_start,
  input  logic                  cs_active,
  input  logic                  mosi_s,
  input  logic [FRAME_W-1:0]    rd_data,
  output logic [CMD_ADDR_W-1:0] reg_addr,
  output logic                  reg_wr_en,
  output logic [CMD_DATA_W-1:0] reg_wr_data,
  output logic                  reg_rd_en,
  output logic                  miso,
  output logic                  miso_oe
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] rx_shift, tx_shift, resp_word;
  logic               done, rd_pend, resp_valid;
  cmd_t               cmd;

  assign cmd = cmd_t'(rx_shift);

  // Shift path: one bit per synchronised rising edge, at most FRAME_W per window
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      rx_shift <= '0;
      tx_shift <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cs_start) begin
        bit_cnt  <= '0;
        tx_shift <= resp_valid ? resp_word : '0;
      end else if (sclk_rise && cs_active && bit_cnt < CNT_W'(FRAME_W)) begin
        rx_shift <= {rx_shift[FRAME_W-2:0], mosi_s};
        tx_shift <= {tx_shift[FRAME_W-2:0], 1'b0};
        bit_cnt  <= bit_cnt + 1'b1;
        done     <= (bit_cnt == CNT_W'(FRAME_W - 1));
      end
    end
  end

  // Access issue and response capture
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr_en   <= 1'b0;
      reg_rd_en   <= 1'b0;
      reg_addr    <= '0;
      reg_wr_data <= '0;
      rd_pend     <= 1'b0;
      resp_valid  <= 1'b0;
      resp_word   <= '0;
      miso_oe     <= 1'b0;
    end else begin
      miso_oe   <= cs_active;
      reg_wr_en <= done & cmd.wr;
      reg_rd_en <= done & ~cmd.wr;
      if (done) begin
        reg_addr    <= cmd.addr;
        reg_wr_data <= cmd.data;
      end
      rd_pend <= reg_rd_en;
      if (rd_pend) begin
        resp_word  <= rd_data;
        resp_valid <= 1'b1;
      end else if (reg_wr_en) begin
        resp_valid <= 1'b0;
      end
    end
  end

  assign miso = tx_shift[FRAME_W-1];

  AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_W)); // R11
  AST_ACCESS_PULSE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en || reg_rd_en) |=> !(reg_wr_en || reg_rd_en)); // R2
  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_rd_en)); // R2
  AST_EMPTY_RESP: assert property (@(posedge clk) disable iff (rst)
    (cs_start && !resp_valid) |=> (tx_shift == '0)); // R4
  AST_RESP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rd_pend |=> resp_valid); // R3
  AST_OE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(miso_oe) |-> (bit_cnt == '0)); // R5
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int                ADDR_W   = 7,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RW_BASE  = 7'h50,
  parameter int                RW_WORDS = 8,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 7'h72,
  parameter logic [2*DATA_W-1:0] ID_VALUE = 16'h407B
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  output logic [2*DATA_W-1:0]   rd_data
);
  localparam int IDX_W = (RW_WORDS > 1) ? $clog2(RW_WORDS) : 1;
  localparam logic [ADDR_W-2:0] BASE_WORD = RW_BASE[ADDR_W-1:1];
  localparam logic [ADDR_W-2:0] ID_WORD   = ID_ADDR[ADDR_W-1:1];

  logic [ADDR_W-2:0] word_addr;
  logic [IDX_W-1:0]  idx;
  logic              in_rw, is_id;
  logic              sel_rw, sel_id;

  assign word_addr = addr[ADDR_W-1:1];
  assign in_rw = (word_addr >= BASE_WORD) &&
                 ({1'b0, word_addr} < ({1'b0, BASE_WORD} + ADDR_W'(RW_WORDS)));
  assign is_id = (word_addr == ID_WORD);
  assign idx   = IDX_W'(word_addr - BASE_WORD);

  // Byte lanes: lane 0 = even address (bits 7:0), lane 1 = odd (bits 15:8)
  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [DATA_W-1:0] mem [RW_WORDS];
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && in_rw && (addr[0] == 1'(ln)))
        mem[idx] <= wr_data;
      if (rd_en)
        q <= mem[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_rw <= 1'b0;
      sel_id <= 1'b0;
    end else if (rd_en) begin
      sel_rw <= in_rw;
      sel_id <= is_id;
    end
  end

  assign rd_data = sel_rw ? {g_lane[1].q, g_lane[0].q} :
                   sel_id ? ID_VALUE : '0;

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_rw && !is_id) |=> (rd_data == '0)); // R9
  AST_ID_CONST: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_id) |=> (rd_data == ID_VALUE)); // R8
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int                    SYNC_STAGES = 2,
  parameter logic [CMD_ADDR_W-1:0] RW_BASE     = 7'h50,
  parameter int                    RW_WORDS    = 8,
  parameter logic [CMD_ADDR_W-1:0] ID_ADDR     = 7'h72,
  parameter logic [FRAME_W-1:0]    ID_VALUE    = 16'h407B
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_csn,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic sclk_rise, cs_start, cs_active, mosi_s;
  logic [CMD_ADDR_W-1:0] reg_addr;
  logic [CMD_DATA_W-1:0] reg_wr_data;
  logic                  reg_wr_en, reg_rd_en;
  logic [FRAME_W-1:0]    reg_rd_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sclk_i(spi_sclk), .csn_i(spi_csn), .mosi_i(spi_mosi),
    .sclk_rise(sclk_rise), .cs_start(cs_start),
    .cs_active(cs_active), .mosi_s(mosi_s)
  );

  spi_frame_engine u_frame (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .cs_start(cs_start),
    .cs_active(cs_active), .mosi_s(mosi_s),
    .rd_data(reg_rd_data),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_reg_bank #(
    .ADDR_W(CMD_ADDR_W), .DATA_W(CMD_DATA_W),
    .RW_BASE(RW_BASE), .RW_WORDS(RW_WORDS),
    .ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)
  ) u_bank (
    .clk(clk), .rst(rst),
    .addr(reg_addr), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .rd_en(reg_rd_en), .rd_data(reg_rd_data)
  );
endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b1;
  logic spi_csn = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit oe_bad;

  always #10 clk = ~clk;

  spi_regport u0 (
    .clk(clk), .rst(rst),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  // {command, expected response shifted out during this frame}
  localparam logic [31:0] VEC [18] = '{
    32'h7200_0000, // R12 first frame after reset is empty; R2 read cmd
    32'h7300_407B, // R8 id word; R3 pipelined response
    32'hDC04_407B, // R7 odd address returned the full word
    32'hDDA5_0000, // R4 previous frame was a write
    32'h5C00_0000, // R4
    32'h5D00_A504, // R6 low then high byte assembled
    32'hD0FF_A504, // R7 even address returns full word
    32'hD112_0000, // R4
    32'h5000_0000, // R4
    32'h5C00_12FF, // R6 lanes independent
    32'hDC77_A504, // R3
    32'h5D00_0000, // R4
    32'hF200_A577, // R6 only low byte changed
    32'h7200_0000, // R4
    32'h2000_407B, // R8 id unchanged after write
    32'hA0AA_0000, // R9 reserved read gives zero
    32'h2000_0000, // R4
    32'h0000_0000  // R9 reserved write had no effect
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic spi_xfer(input logic [31:0] bits, input int nbits, output logic [15:0] rx);
    rx = '0;
    oe_bad = 1'b0;
    @(negedge clk) spi_csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sclk = 1'b0;
      spi_mosi = bits[31-i];
      repeat (HALF) @(negedge clk);
      if (i < 16) rx = {rx[14:0], spi_miso};
      if (spi_miso_oe !== 1'b1) oe_bad = 1'b1;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    spi_csn = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    logic [15:0] rx;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 oe after reset", 16'(spi_miso_oe), 16'h0);
    check("R5 oe idle", 16'(spi_miso_oe), 16'h0);

    foreach (VEC[k]) begin
      spi_xfer({VEC[k][31:16], 16'h0}, 16, rx);
      check($sformatf("R1/R3 vector %0d", k), rx, VEC[k][15:0]);
      check("R5 oe high in frame", 16'(oe_bad), 16'h0);
    end
    check("R5 oe low after frame", 16'(spi_miso_oe), 16'h0);

    // R10: aborted frame carrying a write to 0x50
    spi_xfer({16'h7200, 16'h0}, 16, rx);
    spi_xfer({16'hD000, 16'h0}, 8, rx);
    spi_xfer({16'h5000, 16'h0}, 16, rx);
    check("R10 response resent", rx, 16'h407B);
    spi_xfer({16'h0000, 16'h0}, 16, rx);
    check("R10 no write from partial frame", rx, 16'h12FF);

    // R11: extra edges in one window would encode a write to 0x5D
    spi_xfer({16'h5C00, 16'hDDFF}, 32, rx);
    spi_xfer({16'h5C00, 16'h0}, 16, rx);
    check("R11 first 16 bits taken", rx, 16'hA577);
    spi_xfer({16'h0000, 16'h0}, 16, rx);
    check("R11 extra bits ignored", rx, 16'hA577);

    // R12: reset drops a pending response
    spi_xfer({16'h7200, 16'h0}, 16, rx);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 oe low after reset", 16'(spi_miso_oe), 16'h0);
    spi_xfer({16'h7200, 16'h0}, 16, rx);
    check("R12 empty response after reset", rx, 16'h0000);
    spi_xfer({16'h0000, 16'h0}, 16, rx);
    check("R8 id after reset", rx, 16'h407B);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule